// File: doc/BRIEF.md
# I2C Register-Access Slave with Auto-Incrementing Pointer

This block is the control-port slave of a larger chip. It watches the two I2C bus lines with the fast system clock and pulls SDA low through an open-drain output enable. Through it, a bus master reads and writes a bank of up to 128 eight-bit registers that live outside the block. The block reaches that bank through a plain write strobe port and a combinational read port.

The seven-bit device address has two parts. Its upper six bits are a parameter with the default 100111. Its lowest bit is a strap pin that is captured on the first clock after reset is released. A write transaction carries an address byte, then a pointer byte, then any number of data bytes. In the pointer byte, bit 7 enables auto-increment and bits 6..0 select the register. A read transaction returns register contents starting at the current pointer. The usual way to read is to send a pointer write, then a repeated START, then a read address.

The register ports have no back-pressure. Clock stretching is not supported, so the register bank must accept a write strobe in the cycle it appears. It must also present read data in the same cycle as the index. `wr_en` is a single-cycle strobe with no ready, and `rd_data` is sampled in the cycle the block needs it.

Top module: `i2c_regport`

## Requirements
- R1: An SDA fall while SCL is high is a START and an SDA rise while SCL is high is a STOP. A START is accepted at any time, so a repeated START without a STOP begins a new address phase.
- R2: The first byte after START is received MSB first as seven address bits followed by a R/W bit (1 = read, 0 = write). When the address equals {prefix, latched strap}, the slave pulls SDA low during the ninth clock.
- R3: The strap pin is captured once, on the first clock after reset release. Later changes of the pin do not change the address the slave answers to.
- R4: When the address does not match, the slave does not acknowledge. It produces no register writes and leaves SDA released until the next START or STOP.
- R5: In a write, the byte after the address loads the pointer: bit 7 is the auto-increment flag and bits 6..0 the register index. The slave acknowledges it.
- R6: Each further data byte in a write is acknowledged. It produces exactly one single-cycle `wr_en` pulse carrying the current index on `wr_idx` and the byte on `wr_data`.
- R7: With auto-increment set, the index advances by one after every data byte and wraps from 127 to 0. With it clear, every byte goes to the same index.
- R8: In a read, the slave shifts out `rd_data` for the current index, MSB first. When auto-increment is set, each master ACK advances the index before the next byte.
- R9: After a master NACK in a read, the slave keeps SDA released until the next START or STOP.
- R10: The SDA output enable changes only while the synchronized SCL is low.
- R11: During and right after reset, `sda_oe` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_strap | input | 1 | Address LSB strap, captured at reset release |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_idx | output | 7 | Register index of the write |
| wr_data | output | 8 | Write data byte |
| rd_idx | output | 7 | Register index for read data |
| rd_data | input | 8 | Register contents at `rd_idx`, same cycle |

## Verification
Every SCL or SDA edge passes through two synchronizer flops and one edge register. The slave therefore changes `sda_oe` or pulses `wr_en` about three system clocks after the SCL fall that ends a bit. The read index advances about three clocks after the SCL rise that carries the master ACK. The bench holds every SCL phase for at least five clocks and samples SDA in the middle of each high phase, well past that three-clock latency. It checks register contents and write-pulse counts only after the STOP, when every strobe of the transaction is already due.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_PTR,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } phase_t;

  localparam logic [5:0] DEV_PREFIX_DEF = 6'b100111;
endpackage

// File: rtl/i2c_regport_sync.sv
module i2c_regport_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] dout_q
);
  // STAGES synchronizer flops plus one extra stage for edge detection
  logic [STAGES:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pipe[0] <= '1;
    else        pipe[0] <= din;

  for (genvar k = 1; k <= STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) pipe[k] <= '1;
      else        pipe[k] <= pipe[k-1];
  end

  assign dout   = pipe[STAGES-1];
  assign dout_q = pipe[STAGES];
endmodule

// File: rtl/i2c_regport_ptr.sv
module i2c_regport_ptr #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [7:0]       load_val,
  output logic [IDX_W-1:0] idx,
  output logic             ai
);
  localparam logic [IDX_W-1:0] ONE = {{(IDX_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idx <= '0;
      ai  <= 1'b0;
    end else if (load) begin
      idx <= load_val[IDX_W-1:0];
      ai  <= load_val[7];
    end else if (step && ai) begin
      idx <= idx + ONE;
    end

  AST_PTR_FIXED_NO_AI: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ai && !load) |=> $stable(idx)); // R7
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter logic [5:0] DEV_PREFIX  = DEV_PREFIX_DEF,
  parameter int         IDX_W       = 7,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_strap,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [7:0]       rd_data
);
  localparam int CNT_W = 4;

  // Line synchronization and bus events
  logic [1:0] ln_s, ln_q;
  logic scl_s, sda_s, scl_p, sda_p;
  logic ev_start, ev_stop, ev_rise, ev_fall;

  i2c_regport_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({scl_i, sda_i}),
    .dout  (ln_s),
    .dout_q(ln_q)
  );

  assign scl_s = ln_s[1];
  assign sda_s = ln_s[0];
  assign scl_p = ln_q[1];
  assign sda_p = ln_q[0];

  assign ev_start = scl_s & scl_p & sda_p & ~sda_s;
  assign ev_stop  = scl_s & scl_p & ~sda_p & sda_s;
  assign ev_rise  = scl_s & ~scl_p;
  assign ev_fall  = ~scl_s & scl_p;

  // Strap capture on the first clock after reset release
  logic strap_q, strap_done;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      strap_q    <= 1'b0;
      strap_done <= 1'b0;
    end else if (!strap_done) begin
      strap_q    <= addr_strap;
      strap_done <= 1'b1;
    end

  // Byte sequencer state
  phase_t           phase;
  logic [CNT_W-1:0] bitcnt;
  logic [7:0]       sh, tx;
  logic             in_ack, rw, nack;
  logic             rx_phase, byte_done, addr_hit;
  logic             ptr_load, ptr_step, ptr_ai;
  logic [IDX_W-1:0] ptr_idx;

  assign rx_phase  = (phase == PH_ADDR) || (phase == PH_PTR) || (phase == PH_WDATA);
  assign byte_done = ev_fall && rx_phase && !in_ack && (bitcnt == CNT_W'(8));
  assign addr_hit  = (sh[7:1] == {DEV_PREFIX, strap_q});
  assign ptr_load  = byte_done && (phase == PH_PTR);
  assign ptr_step  = (byte_done && (phase == PH_WDATA)) ||
                     (ev_rise && (phase == PH_RDATA) && in_ack && !sda_s);

  i2c_regport_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ptr_load),
    .step    (ptr_step),
    .load_val(sh),
    .idx     (ptr_idx),
    .ai      (ptr_ai)
  );

  assign rd_idx = ptr_idx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bitcnt  <= '0;
      sh      <= '0;
      tx      <= '0;
      in_ack  <= 1'b0;
      rw      <= 1'b0;
      nack    <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (ev_start) begin
        phase  <= PH_ADDR;
        bitcnt <= '0;
        in_ack <= 1'b0;
        nack   <= 1'b0;
        sda_oe <= 1'b0;
      end else if (ev_stop) begin
        phase  <= PH_IDLE;
        bitcnt <= '0;
        in_ack <= 1'b0;
        nack   <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        case (phase)
          PH_ADDR, PH_PTR, PH_WDATA: begin
            if (ev_rise && !in_ack && bitcnt != CNT_W'(8)) begin
              sh     <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + CNT_W'(1);
            end
            if (ev_fall) begin
              if (in_ack) begin
                in_ack <= 1'b0;
                bitcnt <= '0;
                sda_oe <= 1'b0;
                if (phase == PH_ADDR) begin
                  if (rw) begin
                    phase  <= PH_RDATA;
                    tx     <= rd_data;
                    sda_oe <= ~rd_data[7];
                  end else begin
                    phase <= PH_PTR;
                  end
                end else begin
                  phase <= PH_WDATA;
                end
              end else if (bitcnt == CNT_W'(8)) begin
                if (phase == PH_ADDR && !addr_hit) begin
                  phase <= PH_SKIP;
                end else begin
                  in_ack <= 1'b1;
                  sda_oe <= 1'b1;
                end
                if (phase == PH_ADDR) rw <= sh[0];
                if (phase == PH_WDATA) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= ptr_idx;
                  wr_data <= sh;
                end
              end
            end
          end
          PH_RDATA: begin
            if (ev_rise && in_ack) nack <= sda_s;
            if (ev_fall) begin
              if (in_ack) begin
                in_ack <= 1'b0;
                bitcnt <= '0;
                if (nack) begin
                  phase  <= PH_SKIP;
                  sda_oe <= 1'b0;
                end else begin
                  tx     <= rd_data;
                  sda_oe <= ~rd_data[7];
                end
              end else if (bitcnt == CNT_W'(7)) begin
                in_ack <= 1'b1;
                sda_oe <= 1'b0;
              end else begin
                bitcnt <= bitcnt + CNT_W'(1);
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          end
          default: ;
        endcase
      end
    end

  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s); // R10
  AST_SKIP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |-> !sda_oe); // R4 R9
  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R6
  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_done && $past(strap_done)) |-> $stable(strap_q)); // R3
  AST_WR_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (phase == PH_WDATA)); // R6
endmodule

// File: tb/i2c_regport_tb_top.sv
module i2c_regport_tb_top;
  localparam int Q = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap = 1'b1;
  logic       scl_m = 1'b1;
  logic       md = 1'b1;
  logic       sda_line;
  logic       sda_oe, wr_en;
  logic [6:0] wr_idx, rd_idx;
  logic [7:0] wr_data, rd_data;

  logic [7:0] regs    [128];
  logic [7:0] exp_mem [128];
  int n_chk = 0, n_fail = 0, wr_cnt = 0, oe_bad = 0;
  logic oe_prev = 1'b0;
  bit done = 1'b0;
  logic [7:0] dev_w = 8'h9E;

  always #5 clk = ~clk;

  assign sda_line = md & ~sda_oe;
  assign rd_data  = regs[rd_idx];

  i2c_regport dut_i (
    .clk(clk), .rst_n(rst_n), .addr_strap(strap),
    .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  // Register bank behind the write port
  always @(posedge clk) if (wr_en) begin
    regs[wr_idx] <= wr_data;
    wr_cnt <= wr_cnt + 1;
  end

  // R10: output enable must not move while SCL is high
  always @(negedge clk) begin
    if (rst_n && sda_oe != oe_prev && scl_m) oe_bad = oe_bad + 1;
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    md = 1'b1; scl_m = 1'b1; hold(Q);
    md = 1'b0; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_rstart();
    md = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    md = 1'b0; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    md = 1'b0; hold(Q);
    scl_m = 1'b1; hold(Q);
    md = 1'b1; hold(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      md = b[i]; hold(Q);
      scl_m = 1'b1; hold(2*Q);
      scl_m = 1'b0; hold(Q);
    end
    md = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    ack = (sda_line == 1'b0);
    hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic recv_byte(input bit ack_m, output logic [7:0] b);
    b = '0;
    md = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hold(Q);
      scl_m = 1'b1; hold(Q);
      b = {b[6:0], sda_line};
      hold(Q);
      scl_m = 1'b0; hold(Q);
    end
    md = ack_m ? 1'b0 : 1'b1; hold(Q);
    scl_m = 1'b1; hold(2*Q);
    scl_m = 1'b0; hold(Q);
    md = 1'b1;
  endtask

  function automatic int mem_diff();
    int d = 0;
    for (int i = 0; i < 128; i++) if (regs[i] !== exp_mem[i]) d++;
    return d;
  endfunction

  task automatic wr_txn(input logic [7:0] dev, input logic [7:0] ptrb, input int n,
                        input bit hit);
    bit ack;
    logic [6:0] idx = ptrb[6:0];
    int c0 = wr_cnt;
    bus_start();
    send_byte(dev, ack);
    if (hit) chk(ack, "R2 address ack", ack, 1);
    else     chk(!ack, "R4 mismatch no ack", ack, 0);
    send_byte(ptrb, ack);
    chk(ack == hit, "R5 pointer ack", ack, hit);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d = 8'($urandom);
      send_byte(d, ack);
      chk(ack == hit, hit ? "R6 data ack" : "R4 data ignored", ack, hit);
      if (hit) begin
        exp_mem[idx] = d;
        if (ptrb[7]) idx = idx + 7'd1;
      end
    end
    bus_stop();
    chk((wr_cnt - c0) == (hit ? n : 0), "R6 write pulse count", wr_cnt - c0, hit ? n : 0);
    chk(mem_diff() == 0, "R7 register contents", mem_diff(), 0);
  endtask

  task automatic rd_txn(input logic [7:0] ptrb, input int n);
    bit ack;
    logic [7:0] b;
    logic [6:0] idx = ptrb[6:0];
    bus_start();
    send_byte(dev_w, ack);
    send_byte(ptrb, ack);
    chk(ack, "R5 pointer ack before read", ack, 1);
    bus_rstart();
    send_byte(dev_w | 8'h01, ack);
    chk(ack, "R1 repeated start read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      chk(b == exp_mem[idx], "R8 read data", b, exp_mem[idx]);
      if (ptrb[7]) idx = idx + 7'd1;
    end
    hold(Q);
    chk(sda_oe == 1'b0, "R9 released after nack", sda_oe, 0);
    recv_byte(1'b0, b);
    chk(b == 8'hFF, "R9 no drive after nack", b, 8'hFF);
    bus_stop();
  endtask

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < 128; i++) begin
      regs[i] = 8'($urandom);
      exp_mem[i] = regs[i];
    end
    hold(4);
    chk(sda_oe == 1'b0 && wr_en == 1'b0, "R11 in reset", {sda_oe, wr_en}, 0);
    rst_n = 1'b1;
    hold(3);
    strap = 1'b0;
    chk(sda_oe == 1'b0 && wr_en == 1'b0, "R11 after reset", {sda_oe, wr_en}, 0);

    // R3: strap was 1 at release; pin now 0, address ending in 1 still answers
    wr_txn(8'h9E, 8'h80 | 8'd10, 3, 1'b1);
    wr_txn(8'h9C, 8'h80 | 8'd20, 2, 1'b0); // R3 R4
    // R7: wrap from 127 to 0
    wr_txn(8'h9E, 8'hFF, 3, 1'b1);
    // R7: no auto-increment, same index
    wr_txn(8'h9E, 8'h05, 3, 1'b1);
    rd_txn(8'h80 | 8'd10, 3);
    rd_txn(8'h80 | 8'd126, 4);
    rd_txn(8'h05, 2);

    for (int it = 0; it < 14; it++) begin
      logic [7:0] p = 8'($urandom);
      int n = 1 + int'($urandom % 4);
      case ($urandom % 3)
        0: wr_txn(8'h9E, p, n, 1'b1);
        1: rd_txn(p, n);
        default: begin
          logic [7:0] a = 8'($urandom) & 8'hFE;
          if (a == 8'h9E) a = 8'h40;
          wr_txn(a, p, n, 1'b0); // R4
        end
      endcase
    end

    chk(oe_bad == 0, "R10 oe changes only with SCL low", oe_bad, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule